// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block is the issue stage of a core that keeps many warps resident at once. Each resident warp owns one instruction buffer slot. A fetch port fills the slots at a rate of one instruction per clock, and it may target any warp. A per-warp register scoreboard marks which registers have results still in flight. A warp whose buffered instruction touches no in-flight register is eligible. Among the eligible warps, a rotating-priority picker chooses one to issue.

A warp is 32 threads, and the datapath has 8 lanes. Each issued instruction therefore holds the dispatch port for 4 clocks. During those clocks the lane-group index steps through 0 to 3, and no other warp can start. Results return through a writeback port, which clears one pending register per clock. A warp that still has long-latency results outstanding can go on issuing instructions that do not depend on them.

The low twelve bits of an instruction word carry its register fields. The block does not decode the remaining bits.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `iss_valid` is low and `fetch_ready` is high for every warp index below NUM_WARPS.
- R2: A fetch is taken when `fetch_valid` and `fetch_ready` are both high. `fetch_ready` is low while the slot of `fetch_warp` is occupied, and a refused fetch leaves the buffered instruction unchanged.
- R3: The instruction word holds the destination register in bits [3:0], source A in bits [7:4] and source B in bits [11:8]. A buffered instruction is eligible only when none of these three registers is pending for its warp.
- R4: Issuing marks the issued instruction's destination register as pending for that warp only. A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears that warp's register, and a writeback to another warp does not release it.
- R5: When a writeback clears a register in the same clock that an issue marks it, the register ends up pending.
- R6: The clock after a warp is selected, `iss_valid` rises with `iss_lane_grp`=0. It then holds for 4 clocks with the lane group stepping 0,1,2,3, while `iss_warp` and `iss_instr` stay stable.
- R7: No issue starts while lane groups 0 to 2 are on the port. The next warp may start directly after lane group 3, so back-to-back issues are 4 clocks apart.
- R8: The picker searches upward from a pointer and wraps around, and it takes the first eligible warp. After each issue the pointer moves to the warp after the one issued. At reset the pointer is 0.
- R9: A warp that has pending registers still issues a buffered instruction that uses none of them.
- R10: A warp's slot is freed when it is selected, so `fetch_ready` for that warp is high again by the time lane group 0 is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch offers an instruction |
| fetch_warp | input | WID_W | Target warp slot of the fetch |
| fetch_instr | input | INSTR_W | Instruction word from fetch |
| fetch_ready | output | 1 | Slot of `fetch_warp` is free |
| wb_valid | input | 1 | A result is written back this clock |
| wb_warp | input | WID_W | Warp of the written-back register |
| wb_reg | input | 4 | Register index written back |
| iss_valid | output | 1 | Dispatch port carries an instruction |
| iss_warp | output | WID_W | Warp on the dispatch port |
| iss_instr | output | INSTR_W | Instruction on the dispatch port |
| iss_lane_grp | output | LG_W | Lane group being dispatched (0 to 3) |

## Verification
A corrupted scoreboard bit shows at the ports in one of two ways. Either a dependent instruction reaches `iss_valid` before its writeback, or an instruction never issues after all its writebacks. A stall shows up as a missing issue within a few clocks of the releasing writeback. A corrupted rotation pointer shows as a wrong warp order, which appears in the very next contended pick. An error in the dispatch counter breaks the 0 to 3 lane-group stepping within one issue, or breaks the 4-clock spacing between issues. A slot-occupancy error shows as `fetch_ready` wrongly low in the clock after selection, or as a refused fetch replacing the buffered instruction.

// File: rtl/wis_pkg.sv
package wis_pkg;
    localparam int REG_IDX_W     = 4;
    localparam int NUM_REGS      = 1 << REG_IDX_W;
    localparam int REG_FIELDS_W  = 3 * REG_IDX_W;
    localparam int WARP_THREADS  = 32;
    localparam int DATAPATH_LANES = 8;
    localparam int LANE_GROUPS   = WARP_THREADS / DATAPATH_LANES;

    typedef struct packed {
        logic [REG_IDX_W-1:0] src_b;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] dst;
    } reg_fields_t;
endpackage

// File: rtl/wis_slot_buf.sv
module wis_slot_buf #(
    parameter int NUM_WARPS = 24,
    parameter int INSTR_W   = 32,
    parameter int WID_W     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [WID_W-1:0]                  wr_warp,
    input  logic [INSTR_W-1:0]                wr_instr,
    input  logic                              free_en,
    input  logic [WID_W-1:0]                  free_warp,
    input  logic [WID_W-1:0]                  q_warp,
    output logic                              q_free,
    output logic [NUM_WARPS-1:0]              slot_vld,
    output logic [NUM_WARPS-1:0][INSTR_W-1:0] slot_instr
);
    typedef struct packed {
        logic [NUM_WARPS-1:0]              vld;
        logic [NUM_WARPS-1:0][INSTR_W-1:0] instr;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (free_en && free_warp == WID_W'(w)) begin
                buf_d.vld[w] = 1'b0;
            end
            if (wr_en && wr_warp == WID_W'(w)) begin
                buf_d.vld[w]   = 1'b1;
                buf_d.instr[w] = wr_instr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    always_comb begin
        q_free = 1'b0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (q_warp == WID_W'(w)) q_free = ~buf_q.vld[w];
        end
    end

    assign slot_vld   = buf_q.vld;
    assign slot_instr = buf_q.instr;
endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [WID_W-1:0]              set_warp,
    input  logic [REG_IDX_W-1:0]          set_reg,
    input  logic                          clr_en,
    input  logic [WID_W-1:0]              clr_warp,
    input  logic [REG_IDX_W-1:0]          clr_reg,
    output logic [NUM_WARPS*NUM_REGS-1:0] pend
);
    localparam int BITS = NUM_WARPS * NUM_REGS;

    logic [BITS-1:0] pend_d, pend_q;

    // Clear first, then set: an issue in the same clock wins.
    always_comb begin
        pend_d = pend_q;
        if (clr_en) pend_d[{clr_warp, clr_reg}] = 1'b0;
        if (set_en) pend_d[{set_warp, set_reg}] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic [NUM_WARPS-1:0] req,
    input  logic [WID_W-1:0]     ptr,
    output logic                 gnt_vld,
    output logic [WID_W-1:0]     gnt_idx
);
    // Walk offsets from far to near so the nearest request is written last.
    always_comb begin
        int cand;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int off = NUM_WARPS - 1; off >= 0; off--) begin
            cand = int'(ptr) + off;
            if (cand >= NUM_WARPS) cand = cand - NUM_WARPS;
            if (req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = WID_W'(cand);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int INSTR_W   = 32,
    localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LG_W     = $clog2(LANE_GROUPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid,
    input  logic [WID_W-1:0]     fetch_warp,
    input  logic [INSTR_W-1:0]   fetch_instr,
    output logic                 fetch_ready,
    input  logic                 wb_valid,
    input  logic [WID_W-1:0]     wb_warp,
    input  logic [REG_IDX_W-1:0] wb_reg,
    output logic                 iss_valid,
    output logic [WID_W-1:0]     iss_warp,
    output logic [INSTR_W-1:0]   iss_instr,
    output logic [LG_W-1:0]      iss_lane_grp
);
    localparam logic [LG_W-1:0]  LG_LAST   = LG_W'(LANE_GROUPS - 1);
    localparam logic [WID_W-1:0] WARP_LAST = WID_W'(NUM_WARPS - 1);

    typedef struct packed {
        logic                busy;
        logic [LG_W-1:0]     lg;
        logic [WID_W-1:0]    warp;
        logic [INSTR_W-1:0]  instr;
        logic [WID_W-1:0]    rr_ptr;
    } disp_t;

    disp_t disp_d, disp_q;

    logic [NUM_WARPS-1:0]              slot_vld;
    logic [NUM_WARPS-1:0][INSTR_W-1:0] slot_instr;
    logic [NUM_WARPS*NUM_REGS-1:0]     pend;
    logic [NUM_WARPS-1:0]              elig;
    logic                              gnt_vld;
    logic [WID_W-1:0]                  gnt_idx;
    logic                              can_start;
    logic                              start;
    logic [INSTR_W-1:0]                sel_instr;
    reg_fields_t                       sel_f;
    logic                              fetch_take;

    assign fetch_take = fetch_valid & fetch_ready;

    wis_slot_buf #(
        .NUM_WARPS (NUM_WARPS),
        .INSTR_W   (INSTR_W),
        .WID_W     (WID_W)
    ) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fetch_take),
        .wr_warp    (fetch_warp),
        .wr_instr   (fetch_instr),
        .free_en    (start),
        .free_warp  (gnt_idx),
        .q_warp     (fetch_warp),
        .q_free     (fetch_ready),
        .slot_vld   (slot_vld),
        .slot_instr (slot_instr)
    );

    // Eligibility: slot holds an instruction and none of its registers is in flight.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
        reg_fields_t          f;
        logic [NUM_REGS-1:0]  wp;
        assign f  = reg_fields_t'(slot_instr[w][REG_FIELDS_W-1:0]);
        assign wp = pend[w*NUM_REGS +: NUM_REGS];
        assign elig[w] = slot_vld[w] & ~wp[f.dst] & ~wp[f.src_a] & ~wp[f.src_b];
    end

    wis_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) pick_i (
        .req     (elig),
        .ptr     (disp_q.rr_ptr),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    assign can_start = ~disp_q.busy | (disp_q.lg == LG_LAST);
    assign start     = can_start & gnt_vld;
    assign sel_instr = slot_instr[gnt_idx];
    assign sel_f     = reg_fields_t'(sel_instr[REG_FIELDS_W-1:0]);

    wis_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) sb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (start),
        .set_warp (gnt_idx),
        .set_reg  (sel_f.dst),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .pend     (pend)
    );

    always_comb begin
        disp_d = disp_q;
        if (disp_q.busy) begin
            if (disp_q.lg == LG_LAST) disp_d.busy = 1'b0;
            else                      disp_d.lg   = disp_q.lg + 1'b1;
        end
        if (start) begin
            disp_d.busy   = 1'b1;
            disp_d.lg     = '0;
            disp_d.warp   = gnt_idx;
            disp_d.instr  = sel_instr;
            disp_d.rr_ptr = (gnt_idx == WARP_LAST) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    assign iss_valid    = disp_q.busy;
    assign iss_warp     = disp_q.warp;
    assign iss_instr    = disp_q.instr;
    assign iss_lane_grp = disp_q.lg;
endmodule

// File: rtl/wis_checker.sv
module wis_checker
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 24,
    parameter int INSTR_W   = 32,
    parameter int WID_W     = 5,
    parameter int LG_W      = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          iss_valid,
    input logic [WID_W-1:0]              iss_warp,
    input logic [INSTR_W-1:0]            iss_instr,
    input logic [LG_W-1:0]               iss_lane_grp,
    input logic [NUM_WARPS-1:0]          slot_vld,
    input logic [NUM_WARPS*NUM_REGS-1:0] pend
);
    localparam logic [LG_W-1:0] LAST = LG_W'(LANE_GROUPS - 1);

    reg_fields_t f;
    assign f = reg_fields_t'(iss_instr[REG_FIELDS_W-1:0]);

    logic [NUM_WARPS*NUM_REGS-1:0] pend_prev_q;
    always_ff @(posedge clk) begin
        if (!rst_n) pend_prev_q <= '0;
        else        pend_prev_q <= pend;
    end

    logic first_grp;
    assign first_grp = iss_valid && iss_lane_grp == '0;

    // R6
    lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_lane_grp != LAST |=>
            iss_valid && iss_lane_grp == LG_W'($past(iss_lane_grp) + 1'b1));

    // R6
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_lane_grp != LAST |=> $stable(iss_warp) && $stable(iss_instr));

    // R6
    start_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iss_valid) |-> iss_lane_grp == '0);

    // R7
    after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_lane_grp == LAST |=> !iss_valid || iss_lane_grp == '0);

    // R10
    slot_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_grp |-> !slot_vld[iss_warp]);

    // R4
    dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_grp |-> pend[{iss_warp, f.dst}]);

    // R3
    srcs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_grp |-> !pend_prev_q[{iss_warp, f.src_a}] && !pend_prev_q[{iss_warp, f.src_b}]
                      && !pend_prev_q[{iss_warp, f.dst}]);
endmodule

bind warp_issue_sched wis_checker #(
    .NUM_WARPS (NUM_WARPS),
    .INSTR_W   (INSTR_W),
    .WID_W     (WID_W),
    .LG_W      (LG_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_valid    (iss_valid),
    .iss_warp     (iss_warp),
    .iss_instr    (iss_instr),
    .iss_lane_grp (iss_lane_grp),
    .slot_vld     (slot_vld),
    .pend         (pend)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb_top;
    localparam int NW = 4;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [WW-1:0] fetch_warp = '0;
    logic [31:0]   fetch_instr = '0;
    logic          fetch_ready;
    logic          wb_valid = 1'b0;
    logic [WW-1:0] wb_warp = '0;
    logic [3:0]    wb_reg = '0;
    logic          iss_valid;
    logic [WW-1:0] iss_warp;
    logic [31:0]   iss_instr;
    logic [1:0]    iss_lane_grp;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_log = 0;
    int log_warp [0:127];
    int log_cyc  [0:127];
    logic [31:0] log_instr [0:127];
    logic prev_v = 1'b0;
    logic [1:0] prev_lg = '0;
    logic [WW-1:0] prev_w = '0;
    logic [31:0] prev_i = '0;

    always #10 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .INSTR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_instr(fetch_instr),
        .fetch_ready(fetch_ready),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_instr(iss_instr),
        .iss_lane_grp(iss_lane_grp)
    );

    task automatic chk(input logic ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int d, input int sa, input int sb, input int tag);
        return {tag[19:0], sb[3:0], sa[3:0], d[3:0]};
    endfunction

    always @(posedge clk) cyc++;

    // Port monitor: lane-group stepping and issue log.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && prev_lg != 2'd3)
                chk(iss_valid && iss_lane_grp == prev_lg + 2'd1 && iss_warp == prev_w
                    && iss_instr == prev_i, "R6 lane group step/hold",
                    longint'(iss_lane_grp), longint'(prev_lg + 2'd1));
            if (iss_valid && (!prev_v || prev_lg == 2'd3))
                chk(iss_lane_grp == 2'd0, "R7 new issue starts at group 0",
                    longint'(iss_lane_grp), 0);
            if (iss_valid && iss_lane_grp == 2'd0 && n_log < 128) begin
                log_warp[n_log]  = int'(iss_warp);
                log_instr[n_log] = iss_instr;
                log_cyc[n_log]   = cyc;
                n_log++;
            end
            prev_v  = iss_valid;
            prev_lg = iss_lane_grp;
            prev_w  = iss_warp;
            prev_i  = iss_instr;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fetch(input int w, input logic [31:0] ins);
        fetch_valid = 1'b1;
        fetch_warp  = WW'(w);
        fetch_instr = ins;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic wb(input int w, input int r);
        wb_valid = 1'b1;
        wb_warp  = WW'(w);
        wb_reg   = 4'(r);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic ready_of(input int w, output logic rdy);
        fetch_warp = WW'(w);
        #1;
        rdy = fetch_ready;
    endtask

    task automatic clear_all();
        idle(8);
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < 16; r++)
                wb(w, r);
        idle(2);
    endtask

    initial begin
        logic rdy;
        int base;
        logic [31:0] ia, ib, ic;
        int order [0:3];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!iss_valid, "R1 iss_valid low after reset", longint'(iss_valid), 0);
        for (int w = 0; w < NW; w++) begin
            ready_of(w, rdy);
            chk(rdy, "R1 fetch_ready high after reset", longint'(rdy), 1);
        end
        @(negedge clk);

        // R6 / R10 / R2: single issue timing
        ia = mk(1, 2, 3, 11);
        fetch(2, ia);
        chk(!iss_valid, "R6 no issue the clock after fetch", longint'(iss_valid), 0);
        ready_of(2, rdy);
        chk(!rdy, "R2 fetch_ready low for occupied slot", longint'(rdy), 0);
        @(negedge clk);
        chk(iss_valid && iss_lane_grp == 2'd0, "R6 issue visible with group 0",
            longint'(iss_valid), 1);
        chk(iss_warp == 2'd2 && iss_instr == ia, "R6 issued warp/instr",
            longint'(iss_warp), 2);
        ready_of(2, rdy);
        chk(rdy, "R10 slot freed when group 0 visible", longint'(rdy), 1);
        idle(3);
        chk(iss_valid && iss_lane_grp == 2'd3, "R6 group 3 on fourth clock",
            longint'(iss_lane_grp), 3);
        @(negedge clk);
        chk(!iss_valid, "R6 port idle after four clocks", longint'(iss_valid), 0);
        clear_all();

        // R2 / R3 / R4: refusal, blocking, per-warp release
        fetch(1, mk(4, 0, 0, 21));
        idle(6);
        ib = mk(9, 4, 0, 22);
        ic = mk(10, 0, 0, 23);
        fetch(1, ib);
        ready_of(1, rdy);
        chk(!rdy, "R2 fetch_ready low while blocked", longint'(rdy), 0);
        base = n_log;
        fetch(1, ic);
        idle(10);
        chk(n_log == base, "R3 blocked source holds issue", n_log, base);
        wb(0, 4);
        idle(6);
        chk(n_log == base, "R4 writeback to other warp does not release", n_log, base);
        wb(1, 4);
        idle(6);
        chk(n_log == base + 1, "R3 released after writeback", n_log, base + 1);
        chk(log_instr[base] == ib, "R2 refused fetch left slot unchanged",
            longint'(log_instr[base]), longint'(ib));
        clear_all();

        // R9: independent instruction behind pending register
        fetch(0, mk(5, 0, 0, 31));
        idle(6);
        base = n_log;
        ia = mk(8, 6, 7, 32);
        fetch(0, ia);
        idle(6);
        chk(n_log == base + 1 && log_instr[base] == ia, "R9 independent instr issues",
            n_log, base + 1);
        base = n_log;
        fetch(0, mk(11, 5, 0, 33));
        idle(12);
        chk(n_log == base, "R4 dependent instr waits on pending dst", n_log, base);
        clear_all();

        // R5: same-clock clear and set resolve to set
        fetch(3, mk(9, 0, 0, 41));
        wb_valid = 1'b1;
        wb_warp  = 2'd3;
        wb_reg   = 4'd9;
        @(negedge clk);
        wb_valid = 1'b0;
        chk(iss_valid && iss_warp == 2'd3, "R5 issue coincides with writeback",
            longint'(iss_warp), 3);
        idle(4);
        base = n_log;
        fetch(3, mk(12, 9, 0, 42));
        idle(12);
        chk(n_log == base, "R5 register stays pending", n_log, base);
        wb(3, 9);
        idle(6);
        chk(n_log == base + 1, "R5 issues after later writeback", n_log, base + 1);
        clear_all();

        // R8 / R7: rotation sweep; the first fetched warp issues alone,
        // the other three then follow in rotation order starting after it.
        for (int a = 0; a < NW; a++) begin
            base = n_log;
            fetch(a, mk(10, 11, 12, 100 + a));
            for (int w = NW - 1; w >= 0; w--)
                if (w != a) fetch(w, mk(10, 11, 12, 200 + w));
            idle(24);
            chk(n_log == base + 4, "R8 all four warps issued", n_log, base + 4);
            for (int k = 0; k < 4; k++) begin
                order[k] = (a + k) % NW;
                chk(log_warp[base + k] == order[k], "R8 rotation order",
                    log_warp[base + k], order[k]);
                if (k > 0)
                    chk(log_cyc[base + k] - log_cyc[base + k - 1] == 4,
                        "R7 back-to-back spacing", log_cyc[base + k] - log_cyc[base + k - 1], 4);
            end
            clear_all();
        end

        // R8: pointer skips a non-eligible warp (pointer 0 after warp 3, warp 0 empty)
        base = n_log;
        fetch(3, mk(1, 2, 3, 301));
        fetch(2, mk(1, 2, 3, 302));
        fetch(1, mk(1, 2, 3, 303));
        idle(20);
        chk(n_log == base + 3, "R8 three issues", n_log, base + 3);
        chk(log_warp[base] == 3, "R8 first warp", log_warp[base], 3);
        chk(log_warp[base + 1] == 1, "R8 skip to warp 1", log_warp[base + 1], 1);
        chk(log_warp[base + 2] == 2, "R8 then warp 2", log_warp[base + 2], 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule